// File: doc/BRIEF.md
# Carry-Flag Integer Arithmetic Unit

This unit executes the flag-chained integer operations of a small RISC core on 32-bit operands. These are add with carry, add with signed-overflow detection, subtract with borrow, subtract with signed-overflow detection, and negate with borrow. One status bit, called T, carries state between instructions. It is the carry or borrow input for the chained forms, and each operation overwrites it with a fresh carry, borrow or overflow indication.

The core presents a 16-bit instruction word together with the current destination value (Rn), the current source value (Rm) and the present T bit, and raises a valid strobe. The result and the new T are computed combinationally and captured on the next rising clock edge. Register file reads and writes stay with the core: the unit reports the destination and source indices from the instruction, a write-enable strobe and a T-update strobe. It also reports an unhandled flag when the opcode is not one of its five.

Sequencing is a three-state machine:
- **IDLE** shows that nothing was accepted on the last edge.
- **WRITE** shows that a recognised opcode was captured on the last edge.
- **REJECT** shows that an unrecognised opcode was captured on the last edge.

Every state follows the same transitions on each rising edge:
- valid with a matching opcode leads to WRITE;
- valid with any other opcode leads to REJECT;
- no valid leads to IDLE.

Top module: `carry_alu`

## Requirements
- R1: While reset is low and in the first cycle after it, wr_en_o, t_upd_o and unhandled_o are 0, and result_o and t_o are 0.
- R2: An instruction with bits 15:12 = 3 and bits 3:0 = E is add with carry. The result is Rn + Rm + T modulo 2^32. The new T is 1 exactly when that full sum exceeds 0xFFFFFFFF, which includes Rn + Rm = 0xFFFFFFFF with T = 1.
- R3: Bits 15:12 = 3 and bits 3:0 = F select add with overflow check. The result is Rn + Rm modulo 2^32. The new T is 1 exactly when the signed sum lies outside the 32-bit two's-complement range.
- R4: Bits 15:12 = 3 and bits 3:0 = A select subtract with borrow. The result is Rn − Rm − T modulo 2^32. The new T is 1 exactly when Rm + T exceeds Rn taken as unsigned numbers.
- R5: Bits 15:12 = 3 and bits 3:0 = B select subtract with overflow check. The result is Rn − Rm modulo 2^32. The new T is 1 exactly when the signed difference lies outside the 32-bit two's-complement range.
- R6: Bits 15:12 = 6 and bits 3:0 = A select negate with borrow. The result is 0 − Rm − T modulo 2^32. The new T is 1 exactly when Rm + T is nonzero.
- R7: For a recognised opcode, result_o, t_o, and wr_en_o = t_upd_o = 1 appear in the cycle after the edge where valid_i was high. A cycle without valid_i gives strobes of 0 on the next cycle, and result_o and t_o keep their values.
- R8: Any other opcode taken with valid_i gives the following in the next cycle: unhandled_o = 1, wr_en_o = t_upd_o = 0, result_o equal to the Rn presented and t_o equal to the T presented (both unchanged).
- R9: On every accepted instruction, rd_idx_o takes instruction bits 11:8 and rs_idx_o takes bits 7:4, in the same cycle as the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction and operands are presented this cycle |
| insn_i | input | 16 | Instruction word |
| rn_i | input | 32 | Current destination register value |
| rm_i | input | 32 | Current source register value |
| t_i | input | 1 | Current T bit (carry/borrow input) |
| result_o | output | 32 | Value to write back to the destination register |
| t_o | output | 1 | New T bit |
| wr_en_o | output | 1 | Destination write enable |
| t_upd_o | output | 1 | T update strobe |
| unhandled_o | output | 1 | Opcode was not recognised |
| rd_idx_o | output | 4 | Destination index (instruction bits 11:8) |
| rs_idx_o | output | 4 | Source index (instruction bits 7:4) |

## Verification
Every combination of instruction bits 15:12 and bits 3:0 is presented, so each of the five opcodes is told apart from its 251 neighbours and from each other. Each operation is then swept over a grid of corner operands that includes zero, one, all ones, the signed extremes and alternating patterns, with T both 0 and 1. This grid separates a carry or borrow from only one stage of the chained forms, such as 0xFFFFFFFF + 0 + 1 and 0 − 0 − 1. It also separates a true signed overflow from a mere sign change of the result. Idle cycles between bursts show that the strobes drop and the outputs hold. Back-to-back valid cycles show that each instruction is committed exactly one cycle later.

// File: rtl/carry_alu_pkg.sv
package carry_alu_pkg;

    localparam int INSN_W = 16;
    localparam int NIB_W  = 4;

    localparam logic [NIB_W-1:0] GRP_BINARY = 4'h3;
    localparam logic [NIB_W-1:0] GRP_UNARY  = 4'h6;
    localparam logic [NIB_W-1:0] FN_ADDC    = 4'hE;
    localparam logic [NIB_W-1:0] FN_ADDV    = 4'hF;
    localparam logic [NIB_W-1:0] FN_SUBC    = 4'hA;
    localparam logic [NIB_W-1:0] FN_SUBV    = 4'hB;
    localparam logic [NIB_W-1:0] FN_NEGC    = 4'hA;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ADDC,
        OP_ADDV,
        OP_SUBC,
        OP_SUBV,
        OP_NEGC
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_REJECT
    } alu_state_e;

endpackage

// File: rtl/carry_alu_decode.sv
module carry_alu_decode
    import carry_alu_pkg::*;
(
    input  logic [NIB_W-1:0] grp_i,
    input  logic [NIB_W-1:0] fn_i,
    output alu_op_e          op_o
);
    always_comb begin
        op_o = OP_NONE;
        unique case (grp_i)
            GRP_BINARY: begin
                unique case (fn_i)
                    FN_ADDC: op_o = OP_ADDC;
                    FN_ADDV: op_o = OP_ADDV;
                    FN_SUBC: op_o = OP_SUBC;
                    FN_SUBV: op_o = OP_SUBV;
                    default: op_o = OP_NONE;
                endcase
            end
            GRP_UNARY: begin
                if (fn_i == FN_NEGC) op_o = OP_NEGC;
            end
            default: op_o = OP_NONE;
        endcase
    end
endmodule

// File: rtl/carry_alu_datapath.sv
module carry_alu_datapath
    import carry_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] rn_i,
    input  logic [XLEN-1:0] rm_i,
    input  logic            t_i,
    output logic [XLEN-1:0] res_o,
    output logic            t_o
);
    localparam int MSB = XLEN - 1;
    localparam int EXT = XLEN + 1;

    logic [EXT-1:0] rn_x, rm_x, t_x;
    logic [EXT-1:0] add_c, sub_c, neg_c;
    logic [XLEN-1:0] add_v, sub_v;
    logic            add_ovf, sub_ovf;

    assign rn_x = {1'b0, rn_i};
    assign rm_x = {1'b0, rm_i};
    assign t_x  = {{XLEN{1'b0}}, t_i};

    // Both stages folded into one wide sum: the top bit is the combined carry/borrow.
    assign add_c = rn_x + rm_x + t_x;
    assign sub_c = rn_x - rm_x - t_x;
    assign neg_c = {EXT{1'b0}} - rm_x - t_x;

    assign add_v   = rn_i + rm_i;
    assign sub_v   = rn_i - rm_i;
    assign add_ovf = (rn_i[MSB] == rm_i[MSB]) && (add_v[MSB] != rn_i[MSB]);
    assign sub_ovf = (rn_i[MSB] != rm_i[MSB]) && (sub_v[MSB] != rn_i[MSB]);

    always_comb begin
        res_o = rn_i;
        t_o   = t_i;
        unique case (op_i)
            OP_ADDC: begin res_o = add_c[MSB:0]; t_o = add_c[XLEN]; end
            OP_ADDV: begin res_o = add_v;        t_o = add_ovf;     end
            OP_SUBC: begin res_o = sub_c[MSB:0]; t_o = sub_c[XLEN]; end
            OP_SUBV: begin res_o = sub_v;        t_o = sub_ovf;     end
            OP_NEGC: begin res_o = neg_c[MSB:0]; t_o = neg_c[XLEN]; end
            default: begin res_o = rn_i;         t_o = t_i;         end
        endcase
    end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
    import carry_alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [15:0]     insn_i,
    input  logic [XLEN-1:0] rn_i,
    input  logic [XLEN-1:0] rm_i,
    input  logic            t_i,
    output logic [XLEN-1:0] result_o,
    output logic            t_o,
    output logic            wr_en_o,
    output logic            t_upd_o,
    output logic            unhandled_o,
    output logic [3:0]      rd_idx_o,
    output logic [3:0]      rs_idx_o
);
    alu_op_e         op;
    logic [XLEN-1:0] res_d;
    logic            t_d;
    alu_state_e      state_q, state_d;

    carry_alu_decode u_dec (
        .grp_i (insn_i[15:12]),
        .fn_i  (insn_i[3:0]),
        .op_o  (op)
    );

    carry_alu_datapath #(.XLEN(XLEN)) u_dp (
        .op_i  (op),
        .rn_i  (rn_i),
        .rm_i  (rm_i),
        .t_i   (t_i),
        .res_o (res_d),
        .t_o   (t_d)
    );

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_REJECT: begin
                if (valid_i) state_d = (op == OP_NONE) ? ST_REJECT : ST_WRITE;
                else         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            t_o      <= 1'b0;
            rd_idx_o <= '0;
            rs_idx_o <= '0;
        end else if (valid_i) begin
            result_o <= res_d;
            t_o      <= t_d;
            rd_idx_o <= insn_i[11:8];
            rs_idx_o <= insn_i[7:4];
        end
    end

    always_comb begin
        wr_en_o     = 1'b0;
        t_upd_o     = 1'b0;
        unhandled_o = 1'b0;
        unique case (state_q)
            ST_WRITE:  begin wr_en_o = 1'b1; t_upd_o = 1'b1; end
            ST_REJECT: unhandled_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic [15:0]     insn_i,
    input logic [XLEN-1:0] rn_i,
    input logic [XLEN-1:0] rm_i,
    input logic            t_i,
    input logic [XLEN-1:0] result_o,
    input logic            t_o,
    input logic            wr_en_o,
    input logic            t_upd_o,
    input logic            unhandled_o,
    input logic [3:0]      rd_idx_o,
    input logic [3:0]      rs_idx_o
);
    localparam int MSB = XLEN - 1;

    logic is_addc, is_addv, foreign_grp;
    assign is_addc     = (insn_i[15:12] == 4'h3) && (insn_i[3:0] == 4'hE);
    assign is_addv     = (insn_i[15:12] == 4'h3) && (insn_i[3:0] == 4'hF);
    assign foreign_grp = (insn_i[15:12] != 4'h3) && (insn_i[15:12] != 4'h6);

    p_strobe_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o == t_upd_o);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && unhandled_o));

    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!wr_en_o && !unhandled_o && $stable(result_o) && $stable(t_o)));

    p_addc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_addc) |=>
        (wr_en_o && result_o == $past(rn_i + rm_i + {{(XLEN-1){1'b0}}, t_i})));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && is_addv) |=>
        (t_o == (($past(rn_i[MSB]) == $past(rm_i[MSB])) && (result_o[MSB] != $past(rn_i[MSB])))));

    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && foreign_grp) |=>
        (unhandled_o && result_o == $past(rn_i) && t_o == $past(t_i)));

    p_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (rd_idx_o == $past(insn_i[11:8]) && rs_idx_o == $past(insn_i[7:4])));
endmodule

bind carry_alu carry_alu_chk #(.XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_i),
    .insn_i      (insn_i),
    .rn_i        (rn_i),
    .rm_i        (rm_i),
    .t_i         (t_i),
    .result_o    (result_o),
    .t_o         (t_o),
    .wr_en_o     (wr_en_o),
    .t_upd_o     (t_upd_o),
    .unhandled_o (unhandled_o),
    .rd_idx_o    (rd_idx_o),
    .rs_idx_o    (rs_idx_o)
);

// File: tb/carry_alu_tb_top.sv
module carry_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCORNER = 12;
    localparam logic [31:0] CORNER [NCORNER] = '{
        32'h0000_0000, 32'h0000_0001, 32'h0000_0002, 32'h7FFF_FFFF,
        32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
        32'h5555_5555, 32'hAAAA_AAAA, 32'h1234_5678, 32'h0000_FFFF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [31:0] rn_i = '0, rm_i = '0;
    logic        t_i = 1'b0;
    logic [31:0] result_o;
    logic        t_o, wr_en_o, t_upd_o, unhandled_o;
    logic [3:0]  rd_idx_o, rs_idx_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    carry_alu dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
        .rn_i(rn_i), .rm_i(rm_i), .t_i(t_i), .result_o(result_o), .t_o(t_o),
        .wr_en_o(wr_en_o), .t_upd_o(t_upd_o), .unhandled_o(unhandled_o),
        .rd_idx_o(rd_idx_o), .rs_idx_o(rs_idx_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model built from the arithmetic meaning of each requirement.
    task automatic model(input logic [15:0] insn, input logic [31:0] rn, input logic [31:0] rm,
                         input logic t, output bit known, output logic [31:0] res,
                         output logic texp, output string req);
        longint unsigned un, um, ut;
        longint sn, sm, sr;
        un = longint'(rn); um = longint'(rm); ut = longint'(t);
        sn = longint'($signed(rn)); sm = longint'($signed(rm));
        known = 1; res = rn; texp = t; req = "R8";
        if (insn[15:12] == 4'h3 && insn[3:0] == 4'hE) begin
            req = "R2"; res = 32'(un + um + ut); texp = (un + um + ut) > 64'hFFFF_FFFF;
        end else if (insn[15:12] == 4'h3 && insn[3:0] == 4'hF) begin
            req = "R3"; sr = sn + sm; res = 32'(sr);
            texp = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end else if (insn[15:12] == 4'h3 && insn[3:0] == 4'hA) begin
            req = "R4"; res = 32'(un - um - ut); texp = (um + ut) > un;
        end else if (insn[15:12] == 4'h3 && insn[3:0] == 4'hB) begin
            req = "R5"; sr = sn - sm; res = 32'(sr);
            texp = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        end else if (insn[15:12] == 4'h6 && insn[3:0] == 4'hA) begin
            req = "R6"; res = 32'(64'd0 - um - ut); texp = (um + ut) != 0;
        end else begin
            known = 0;
        end
    endtask

    // Called at a negedge; drives one instruction and checks it at the next negedge.
    task automatic issue(input logic [15:0] insn, input logic [31:0] rn,
                         input logic [31:0] rm, input logic t);
        bit known; logic [31:0] res; logic texp; string req;
        model(insn, rn, rm, t, known, res, texp, req);
        valid_i = 1'b1; insn_i = insn; rn_i = rn; rm_i = rm; t_i = t;
        @(negedge clk);
        check(req, "result", result_o, res);
        check(req, "t", {31'b0, t_o}, {31'b0, texp});
        check(known ? "R7" : "R8", "wr_en", {31'b0, wr_en_o}, {31'b0, known});
        check(known ? "R7" : "R8", "t_upd", {31'b0, t_upd_o}, {31'b0, known});
        check("R8", "unhandled", {31'b0, unhandled_o}, {31'b0, !known});
        check("R9", "idx", {24'b0, rd_idx_o, rs_idx_o}, {24'b0, insn[11:8], insn[7:4]});
    endtask

    task automatic idle_check;
        logic [31:0] r; logic tt;
        r = result_o; tt = t_o;
        valid_i = 1'b0; rn_i = ~rn_i; t_i = ~t_i;
        @(negedge clk);
        check("R7", "idle wr_en", {31'b0, wr_en_o}, 32'd0);
        check("R7", "idle unhandled", {31'b0, unhandled_o}, 32'd0);
        check("R7", "idle result hold", result_o, r);
        check("R7", "idle t hold", {31'b0, t_o}, {31'b0, tt});
    endtask

    initial begin
        logic [3:0] fns [5] = '{4'hE, 4'hF, 4'hA, 4'hB, 4'hA};
        logic [3:0] grps [5] = '{4'h3, 4'h3, 4'h3, 4'h3, 4'h6};
        repeat (3) @(negedge clk);
        check("R1", "reset strobes", {29'b0, wr_en_o, t_upd_o, unhandled_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset strobes", {29'b0, wr_en_o, t_upd_o, unhandled_o}, 32'd0);
        check("R1", "post-reset result", result_o, 32'd0);
        check("R1", "post-reset t", {31'b0, t_o}, 32'd0);

        // Named single-stage carry/borrow corners
        issue(16'h312E, 32'hFFFF_FFFF, 32'h0, 1'b1);   // R2: carry from +T stage only
        issue(16'h345A, 32'h0, 32'h0, 1'b1);           // R4: borrow from -T stage only
        issue(16'h678A, 32'h0, 32'h0, 1'b1);           // R6: zero negation, T borrows
        issue(16'h678A, 32'h0, 32'h0, 1'b0);           // R6: no borrow at all
        issue(16'h39AF, 32'h7FFF_FFFF, 32'h1, 1'b1);   // R3: positive overflow
        issue(16'h3BCB, 32'h8000_0000, 32'h1, 1'b0);   // R5: negative overflow
        idle_check();

        // Decode sweep over group and function nibbles
        for (int g = 0; g < 16; g++) begin
            for (int f = 0; f < 16; f++) begin
                issue({g[3:0], 4'h5, 4'h9, f[3:0]}, 32'h8000_0001, 32'hFFFF_FFFF, f[0]);
            end
        end
        idle_check();

        // Operand grid per operation, both T values
        for (int o = 0; o < 5; o++) begin
            for (int a = 0; a < NCORNER; a++) begin
                for (int b = 0; b < NCORNER; b++) begin
                    for (int t = 0; t < 2; t++) begin
                        issue({grps[o], a[3:0], b[3:0], fns[o]}, CORNER[a], CORNER[b], t[0]);
                    end
                end
            end
            idle_check();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule